// File: doc/BRIEF.md
# Single-Step Non-Restoring Divider

This block carries out one iteration of a non-restoring binary division for each request. The caller presents the current partial remainder word, the divisor and three flags: the quotient-tracking bit Q, the divisor-sign bit M and the carry bit T. The block shifts T into the bottom of the remainder and moves the top bit out. It then adds or subtracts the divisor, with the choice made from the old Q and M. It returns the new remainder, a new Q that encodes the carry or borrow of that operation, and a new T that is the next quotient bit.

The caller owns the iteration. It sets M, Q and T before the first step. It rotates the low dividend word through T between steps, feeds the returned Q and T back into the next request, and collects the quotient bits. A request is one cycle with `valid_i` high. The result is registered and appears on the following cycle together with a one-cycle `done_o` pulse. The outputs then hold until the next request.

Top module: `nrdiv_step_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rem_o`, `q_o`, `t_o` and `done_o` all become 0.
- R2: The step works on the word `{rem_i[W-2:0], t_i}`, which is the remainder shifted left by one with `t_i` entering bit 0. The bit shifted out, `rem_i[W-1]`, is the intermediate Q.
- R3: When `q_i` equals `m_i`, `rem_o` is the shifted word minus `dvs_i`, modulo 2^W. The indicator is the borrow, meaning the unsigned result is greater than the shifted word.
- R4: When `q_i` differs from `m_i`, `rem_o` is the shifted word plus `dvs_i`, modulo 2^W. The indicator is the carry, meaning the unsigned result is less than the shifted word.
- R5: Subtract, `q_i`=0 and `m_i`=0: new Q is the indicator if the intermediate Q is 0, and its inverse if it is 1.
- R6: Subtract, `q_i`=1 and `m_i`=1: new Q is the inverse of the indicator if the intermediate Q is 0, and the indicator if it is 1.
- R7: Add, `q_i`=0 and `m_i`=1: new Q is the inverse of the indicator if the intermediate Q is 0, and the indicator if it is 1. Add, `q_i`=1 and `m_i`=0: new Q is the indicator if the intermediate Q is 0, and its inverse if it is 1.
- R8: New T is 1 when the new Q equals `m_i`, and 0 otherwise.
- R9: A request with `valid_i` high at a rising edge shows its result on `rem_o`, `q_o` and `t_o` after that edge, and `done_o` is high for exactly that one cycle.
- R10: While `valid_i` is low, `rem_o`, `q_o` and `t_o` keep their values and `done_o` is 0.
- R11: Suppose the caller starts with Q=M=T=0 and the high dividend word below the divisor. Before each of 32 steps it rotates the low word left through T, and it rotates once more after the last step. The low word then holds the unsigned quotient of the 64-bit dividend by the divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Step request strobe |
| rem_i | input | W | Partial remainder before the step |
| dvs_i | input | W | Divisor |
| q_i | input | 1 | Q flag before the step |
| m_i | input | 1 | M flag (divisor sign) |
| t_i | input | 1 | T flag, shifted into bit 0 |
| rem_o | output | W | Partial remainder after the step |
| q_o | output | 1 | Updated Q flag |
| t_o | output | 1 | Updated T flag (quotient bit) |
| done_o | output | 1 | One-cycle pulse when a result is presented |

## Verification
Each result passes through exactly one register. The bench drives a request on a falling edge and reads `rem_o`, `q_o`, `t_o` and `done_o` on the next falling edge, which is half a cycle after the capturing edge. One cycle later it reads them again to confirm that `done_o` has dropped and the result has held. Every directed step has hand-worked constants for all four Q/M combinations, with and without a carry or borrow. The full-division scenario chains 32 such request/read pairs and compares the quotient with the bench's own 64-by-32 division.

// File: rtl/nrdiv_pkg.sv
// Package: shared types for the single-step non-restoring divider.
// Assumes nothing beyond the width chosen at the top level.
package nrdiv_pkg;

    // Arithmetic operation picked for one step
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } step_op_e;

endpackage

// File: rtl/nrdiv_shift_sel.sv
// Module: nrdiv_shift_sel
// Shifts the partial remainder left by one with the T flag entering bit 0.
// Reports the bit shifted out and chooses add or subtract from old Q and M.
// Assumes W >= 2. Purely combinational.
module nrdiv_shift_sel
    import nrdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic         t_in,
    input  logic         q_in,
    input  logic         m_in,
    output logic [W-1:0] shifted,
    output logic         mid_q,
    output step_op_e     op
);

    // Shift, capture the outgoing top bit, and pick the operation
    always_comb begin
        mid_q   = rem_in[W-1];
        shifted = {rem_in[W-2:0], t_in};
        op      = (q_in == m_in) ? OP_SUB : OP_ADD;
    end

endmodule

// File: rtl/nrdiv_addsub.sv
// Module: nrdiv_addsub
// Adds or subtracts the divisor using a single W+1 bit adder.
// ind is the unsigned carry for add and the unsigned borrow for subtract.
// Purely combinational.
module nrdiv_addsub
    import nrdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  step_op_e     op,
    output logic [W-1:0] sum,
    output logic         ind
);

    localparam int WX = W + 1;

    logic [WX-1:0] wide;
    logic [W-1:0]  b_eff;
    logic          is_sub;

    // One adder: subtraction is a + ~b + 1, and the top bit is then "no borrow"
    always_comb begin
        is_sub = (op == OP_SUB);
        b_eff  = is_sub ? ~b : b;
        wide   = {1'b0, a} + {1'b0, b_eff} + {{(WX-1){1'b0}}, is_sub};
        sum    = wide[W-1:0];
        ind    = is_sub ? ~wide[W] : wide[W];
    end

endmodule

// File: rtl/nrdiv_q_resolve.sv
// Module: nrdiv_q_resolve
// Derives the new Q from the old Q, M, the intermediate Q and the indicator.
// The new T is 1 when the new Q equals M. Purely combinational.
module nrdiv_q_resolve (
    input  logic old_q,
    input  logic m_in,
    input  logic mid_q,
    input  logic ind,
    output logic new_q,
    output logic new_t
);

    // Per-case Q update table, then the T rule
    always_comb begin
        unique case ({old_q, m_in})
            2'b00:   new_q = mid_q ? ~ind :  ind;   // R5 subtract
            2'b11:   new_q = mid_q ?  ind : ~ind;   // R6 subtract
            2'b01:   new_q = mid_q ?  ind : ~ind;   // R7 add
            default: new_q = mid_q ? ~ind :  ind;   // R7 add, old_q=1 m=0
        endcase
        new_t = (new_q == m_in);                    // R8
    end

endmodule

// File: rtl/nrdiv_step_unit.sv
// Module: nrdiv_step_unit (top)
// One non-restoring division step per valid_i cycle. The result is registered
// and shown one cycle later with a done_o pulse, and it holds until the next
// request. Assumes the caller sequences the iterations and sets up M.
module nrdiv_step_unit
    import nrdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvs_i,
    input  logic         q_i,
    input  logic         m_i,
    input  logic         t_i,
    output logic [W-1:0] rem_o,
    output logic         q_o,
    output logic         t_o,
    output logic         done_o
);

    logic [W-1:0] shifted;
    logic         mid_q;
    step_op_e     op;
    logic [W-1:0] sum;
    logic         ind;
    logic         nq;
    logic         nt;

    nrdiv_shift_sel #(.W(W)) u_shift (
        .rem_in  (rem_i),
        .t_in    (t_i),
        .q_in    (q_i),
        .m_in    (m_i),
        .shifted (shifted),
        .mid_q   (mid_q),
        .op      (op)
    );

    nrdiv_addsub #(.W(W)) u_addsub (
        .a   (shifted),
        .b   (dvs_i),
        .op  (op),
        .sum (sum),
        .ind (ind)
    );

    nrdiv_q_resolve u_qres (
        .old_q (q_i),
        .m_in  (m_i),
        .mid_q (mid_q),
        .ind   (ind),
        .new_q (nq),
        .new_t (nt)
    );

    // Result register: load on request, hold otherwise, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_o <= '0;
            q_o   <= 1'b0;
            t_o   <= 1'b0;
        end else if (valid_i) begin
            rem_o <= sum;
            q_o   <= nq;
            t_o   <= nt;
        end
    end

    // Completion pulse: high for the cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= valid_i;
    end

    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    a_r10_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(rem_o) && $stable(q_o) && $stable(t_o)));

    a_r8_t_rule: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (t_o == (q_o == $past(m_i))));

    a_r3_sub_value: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (q_i == m_i)) |=>
        (rem_o == ($past({rem_i[W-2:0], t_i}) - $past(dvs_i))));

    a_r4_add_value: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (q_i != m_i)) |=>
        (rem_o == ($past({rem_i[W-2:0], t_i}) + $past(dvs_i))));

    a_r3_borrow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUB) |-> (ind == (sum > shifted)));

    a_r4_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |-> (ind == (sum < shifted)));

endmodule

// File: tb/nrdiv_step_unit_test.sv
`timescale 1ns/1ps
module nrdiv_step_unit_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [W-1:0] rem_i = '0;
    logic [W-1:0] dvs_i = '0;
    logic         q_i = 1'b0;
    logic         m_i = 1'b0;
    logic         t_i = 1'b0;
    logic [W-1:0] rem_o;
    logic         q_o;
    logic         t_o;
    logic         done_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    nrdiv_step_unit #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .rem_i(rem_i), .dvs_i(dvs_i), .q_i(q_i), .m_i(m_i), .t_i(t_i),
        .rem_o(rem_o), .q_o(q_o), .t_o(t_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request: drive on a falling edge, read one falling edge later
    task automatic do_step(input logic [W-1:0] r, input logic [W-1:0] d,
                           input logic q, input logic m, input logic t);
        @(negedge clk);
        rem_i = r; dvs_i = d; q_i = q; m_i = m; t_i = t; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // Directed step with hand-worked expected values, plus done and hold checks
    task automatic step_case(input string req, input logic [W-1:0] r, input logic [W-1:0] d,
                             input logic q, input logic m, input logic t,
                             input logic [W-1:0] er, input logic eq, input logic et);
        do_step(r, d, q, m, t);
        check({req, " rem"}, 64'(rem_o), 64'(er));
        check({req, " q"},   64'(q_o),   64'(eq));
        check({req, " t"},   64'(t_o),   64'(et));
        check("R9 done pulse", 64'(done_o), 64'd1);
        rem_i = ~r; dvs_i = ~d; q_i = ~q; t_i = ~t;
        @(negedge clk);
        check("R9 done drops", 64'(done_o), 64'd0);
        check("R10 hold", {rem_o, 30'd0, q_o, t_o}, {er, 30'd0, eq, et});
    endtask

    task automatic test_reset();
        check("R1 reset", {rem_o, 29'd0, q_o, t_o, done_o}, 64'd0);
    endtask

    task automatic test_steps();
        step_case("R5 R3 no borrow", 32'h0000_0005, 32'd3, 1'b0, 1'b0, 1'b1,
                  32'h0000_0008, 1'b0, 1'b1);
        step_case("R5 R3 borrow",    32'h0000_0001, 32'd5, 1'b0, 1'b0, 1'b0,
                  32'hFFFF_FFFD, 1'b1, 1'b0);
        step_case("R6 R2 top bit",   32'h8000_0000, 32'd1, 1'b1, 1'b1, 1'b0,
                  32'hFFFF_FFFF, 1'b1, 1'b1);
        step_case("R7 R4 carry m1",  32'h7FFF_FFFF, 32'h10, 1'b0, 1'b1, 1'b1,
                  32'h0000_000F, 1'b0, 1'b0);
        step_case("R7 R4 top bit m1", 32'h8000_0000, 32'd5, 1'b0, 1'b1, 1'b0,
                  32'h0000_0005, 1'b0, 1'b0);
        step_case("R7 R4 no carry m0", 32'h4000_0000, 32'd2, 1'b1, 1'b0, 1'b0,
                  32'h8000_0002, 1'b0, 1'b1);
        step_case("R7 R8 carry m0",  32'hC000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b1,
                  32'h0000_0001, 1'b0, 1'b1);
    endtask

    // Full 32-step unsigned division against the bench's own division
    task automatic test_divide(input logic [W-1:0] hi, input logic [W-1:0] lo,
                               input logic [W-1:0] d);
        logic [W-1:0] h = hi;
        logic [W-1:0] l = lo;
        logic         q = 1'b0;
        logic         t = 1'b0;
        logic         nt;
        logic [63:0]  exp = {hi, lo} / {32'd0, d};
        for (int i = 0; i < 32; i++) begin
            nt = l[W-1];
            l  = {l[W-2:0], t};
            do_step(h, d, q, 1'b0, nt);
            h = rem_o; q = q_o; t = t_o;
        end
        l = {l[W-2:0], t};
        check("R11 quotient", 64'(l), {32'd0, exp[31:0]});
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_steps();
        test_divide(32'd0, 32'd100, 32'd7);
        test_divide(32'd0, 32'hFFFF_FFFF, 32'd1);
        test_divide(32'd5, 32'h1234_5678, 32'h1000_0001);
        test_divide(32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000);
        test_divide(32'd0, 32'd3, 32'd10);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule